// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor

This block keeps the single reservation that a load-reserved / store-conditional pair relies on. A load-reserved command opens a reservation on the granule that holds its address. A store-conditional command then either succeeds or fails. Success needs a live reservation on the same granule. Either way the store-conditional closes the reservation.

Three things remove a reservation besides a store-conditional: an external clear input, which can be raised in any cycle and has nothing to do with bus activity; an ordinary store that hits the reserved granule, when that option is enabled; and reset. The block answers every command with a one-cycle response whose code stands in for a bus transfer termination. A failed store-conditional ends normally, but its code carries the conditional-fail value.

Command decode, the real bus protocol and coherency snooping belong to the surrounding logic. Here a single command strobe with an opcode and an address stands in for them.

Top module: `rsv_monitor`

## Requirements
- R1: After reset, rsv_active is 0 and resp_valid is 0.
- R2: A load-reserved (cmd_op 2'd1) accepted without ext_clear sets rsv_active in the next cycle. rsv_addr then shows the command address with its low GRAN_LOG2 bits (2 by default, a 4-byte granule) forced to zero. A later load-reserved replaces the held address.
- R3: A held reservation survives plain loads (cmd_op 2'd0), plain stores to another granule (cmd_op 2'd2) and idle cycles, and rsv_addr stays unchanged.
- R4: ext_clear high in any cycle, with or without a command, leaves rsv_active at 0 in the next cycle and produces no response by itself.
- R5: A store-conditional (cmd_op 2'd3) succeeds when a reservation is held and its address matches the reserved granule (they differ only in the low GRAN_LOG2 bits). Its response has resp_code 2'b00 and sc_wr_en 1.
- R6: A store-conditional to a different granule fails: resp_code 2'b10 (conditional fail, normal termination) and sc_wr_en 0.
- R7: A store-conditional with no reservation fails with resp_code 2'b10 and sc_wr_en 0.
- R8: Every store-conditional, whether it succeeds or fails, leaves rsv_active at 0 in the next cycle.
- R9: When ext_clear and a load-reserved come in the same cycle, the clear wins and no reservation is left. The load still gets resp_code 2'b00.
- R10: When ext_clear comes in the same cycle as a store-conditional, the store-conditional fails with resp_code 2'b10.
- R11: With CLR_ON_STORE set (the default), a plain store that hits the reserved granule removes the reservation. The store itself completes with resp_code 2'b00 and sc_wr_en 1.
- R12: Every accepted command gives exactly one resp_valid pulse one cycle later, and no response appears without a command. A plain load answers with resp_code 2'b00 and sc_wr_en 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_op | input | 2 | 0 load, 1 load-reserved, 2 store, 3 store-conditional |
| cmd_addr | input | ADDR_W | Byte address of the command |
| ext_clear | input | 1 | Removes the reservation, independent of commands |
| rsv_active | output | 1 | A reservation is held |
| rsv_addr | output | ADDR_W | Granule-aligned reserved address |
| resp_valid | output | 1 | Termination pulse for the previous cycle's command |
| resp_code | output | 2 | 2'b00 normal, 2'b10 conditional fail |
| sc_wr_en | output | 1 | The terminated command performs its write |

## Verification
Every result of this block lands exactly one clock edge after its stimulus. The response pulse with its code and write flag, the new value of rsv_active and the captured rsv_addr all come out of registers written on the same edge that samples the command. The bench drives inputs on the falling edge. It files the expected termination in its queue just after the following rising edge. The monitor pops that entry at the next falling edge, so each response is compared in the one cycle where it may appear. The reservation status is compared at the same point, right after the edge that loaded it.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      OP_LOAD       = 2'd0,
      OP_LOAD_RES   = 2'd1,
      OP_STORE      = 2'd2,
      OP_STORE_COND = 2'd3
   } rsv_op_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] RESP_XFAIL = 2'b10;

   typedef struct packed {
      logic       valid;
      logic [1:0] code;
      logic       wr;
   } rsv_resp_t;

endpackage

// File: rtl/rsv_gran_cmp.sv
module rsv_gran_cmp #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 2
) (
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              same_gran
);
   localparam logic [ADDR_W-1:0] GMASK = {ADDR_W{1'b1}} << GRAN_LOG2;

   generate
      if (GRAN_LOG2 == 0) begin : g_exact
         assign same_gran = (addr_a == addr_b);
      end else begin : g_masked
         assign same_gran = (((addr_a ^ addr_b) & GMASK) == '0);
      end
   endgenerate
endmodule

// File: rtl/rsv_state.sv
module rsv_state #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_req,
   input  logic              kill_req,
   input  logic [ADDR_W-1:0] set_addr,
   output logic              active,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] GMASK = {ADDR_W{1'b1}} << GRAN_LOG2;

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
      end else if (kill_req) begin
         active_q <= 1'b0;
      end else if (set_req) begin
         active_q <= 1'b1;
         addr_q   <= set_addr & GMASK;
      end
   end

   assign active = active_q;
   assign addr   = addr_q;
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp
   import rsv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rsv_resp_t resp_d,
   output rsv_resp_t resp_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_q <= '{valid: 1'b0, code: RESP_OKAY, wr: 1'b0};
      end else begin
         resp_q <= resp_d;
      end
   end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
   import rsv_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int GRAN_LOG2    = 2,
   parameter bit CLR_ON_STORE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              ext_clear,
   output logic              rsv_active,
   output logic [ADDR_W-1:0] rsv_addr,
   output logic              resp_valid,
   output logic [1:0]        resp_code,
   output logic              sc_wr_en
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("rsv_monitor: ADDR_W must be at least 2");
      end
      if (GRAN_LOG2 < 0 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
         $error("rsv_monitor: GRAN_LOG2 must lie in 0..ADDR_W-1");
      end
   endgenerate

   rsv_op_e   op;
   logic      is_lr, is_st, is_sc;
   logic      hit;
   logic      sc_ok;
   logic      store_kill;
   logic      set_req, kill_req;
   rsv_resp_t resp_d, resp_q;

   assign op    = rsv_op_e'(cmd_op);
   assign is_lr = cmd_valid && (op == OP_LOAD_RES);
   assign is_st = cmd_valid && (op == OP_STORE);
   assign is_sc = cmd_valid && (op == OP_STORE_COND);

   rsv_gran_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_cmp (
      .addr_a    (cmd_addr),
      .addr_b    (rsv_addr),
      .same_gran (hit)
   );

   generate
      if (CLR_ON_STORE) begin : g_store_kill
         assign store_kill = is_st && rsv_active && hit;
      end else begin : g_store_keep
         assign store_kill = 1'b0;
      end
   endgenerate

   // the external clear takes priority over everything arriving in the same cycle
   assign sc_ok    = is_sc && rsv_active && !ext_clear && hit;
   assign set_req  = is_lr && !ext_clear;
   assign kill_req = ext_clear || is_sc || store_kill;

   rsv_state #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (set_req),
      .kill_req (kill_req),
      .set_addr (cmd_addr),
      .active   (rsv_active),
      .addr     (rsv_addr)
   );

   always_comb begin
      resp_d.valid = cmd_valid;
      resp_d.code  = (is_sc && !sc_ok) ? RESP_XFAIL : RESP_OKAY;
      resp_d.wr    = is_st || sc_ok;
   end

   rsv_resp i_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .resp_d (resp_d),
      .resp_q (resp_q)
   );

   assign resp_valid = resp_q.valid;
   assign resp_code  = resp_q.code;
   assign sc_wr_en   = resp_q.wr;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk
   import rsv_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              ext_clear,
   input logic              rsv_active,
   input logic [ADDR_W-1:0] rsv_addr,
   input logic              resp_valid,
   input logic [1:0]        resp_code,
   input logic              sc_wr_en
);
   localparam logic [ADDR_W-1:0] GMASK = {ADDR_W{1'b1}} << GRAN_LOG2;

   logic c_lr, c_ld, c_sc;
   assign c_lr = cmd_valid && (cmd_op == OP_LOAD_RES);
   assign c_ld = cmd_valid && (cmd_op == OP_LOAD);
   assign c_sc = cmd_valid && (cmd_op == OP_STORE_COND);

   AST_LR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      c_lr && !ext_clear |=> rsv_active); // R2
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_active |-> ((rsv_addr & ~GMASK) == '0)); // R2
   AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsv_active && !c_lr |=> !rsv_active); // R2
   AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_active && !ext_clear && c_ld |=> rsv_active && $stable(rsv_addr)); // R3
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clear |=> !rsv_active); // R4
   AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc |=> !rsv_active); // R8
   AST_SC_NO_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && !rsv_active |=> resp_code == RESP_XFAIL && !sc_wr_en); // R7
   AST_SC_CLEAR_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc && ext_clear |=> resp_code == RESP_XFAIL); // R10
   AST_XFAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_code == RESP_XFAIL |-> !sc_wr_en); // R6
   AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid); // R12
   AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid); // R12
endmodule

bind rsv_monitor rsv_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_rsv_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .ext_clear  (ext_clear),
   .rsv_active (rsv_active),
   .rsv_addr   (rsv_addr),
   .resp_valid (resp_valid),
   .resp_code  (resp_code),
   .sc_wr_en   (sc_wr_en)
);

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;
   localparam int          CLK_P = 10;
   localparam int          AW    = 32;
   localparam logic [AW-1:0] MASK = ~32'h3;

   typedef struct {
      logic [1:0] code;
      logic       wr;
      string      tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic          ext_clear = 1'b0;
   logic          rsv_active;
   logic [AW-1:0] rsv_addr;
   logic          resp_valid;
   logic [1:0]    resp_code;
   logic          sc_wr_en;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;
   exp_t exp_q[$];

   logic          m_rsv  = 1'b0;
   logic [AW-1:0] m_addr = '0;

   rsv_monitor #(.ADDR_W(AW)) i_rsv_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .ext_clear  (ext_clear),
      .rsv_active (rsv_active),
      .rsv_addr   (rsv_addr),
      .resp_valid (resp_valid),
      .resp_code  (resp_code),
      .sc_wr_en   (sc_wr_en)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   // monitor: pops one expected termination per response pulse
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (resp_valid) begin
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL R12 stray response: actual=1 expected=0");
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(AW'(resp_code), AW'(e.code), {e.tag, " resp_code"});
               check(AW'(sc_wr_en),  AW'(e.wr),   {e.tag, " sc_wr_en"});
            end
         end else if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++; bad++;
            $display("FAIL R12 missing response for %s: actual=0 expected=1", e.tag);
         end
      end
   end

   task automatic issue(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic clr, input string tag);
      exp_t e;
      logic hit;
      @(negedge clk);
      cmd_valid = v; cmd_op = op; cmd_addr = a; ext_clear = clr;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0; ext_clear = 1'b0;
      hit = ((a ^ m_addr) & MASK) == '0;
      e.tag = tag; e.code = 2'b00; e.wr = 1'b0;
      if (v) begin
         case (op)
            2'd1: if (!clr) begin m_rsv = 1'b1; m_addr = a & MASK; end
            2'd2: begin e.wr = 1'b1; if (m_rsv && hit) m_rsv = 1'b0; end
            2'd3: begin
               if (m_rsv && !clr && hit) e.wr = 1'b1;
               else e.code = 2'b10;
               m_rsv = 1'b0;
            end
            default: ;
         endcase
         exp_q.push_back(e);
      end
      if (clr) m_rsv = 1'b0;
      check(AW'(rsv_active), AW'(m_rsv), {tag, " rsv_active"});
      if (m_rsv) check(rsv_addr, m_addr, {tag, " rsv_addr"});
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(AW'(rsv_active), '0, "R1 reset rsv_active");
      check(AW'(resp_valid), '0, "R1 reset resp_valid");
      rst_n = 1'b1;

      issue(1, 2'd3, 32'h0000_0100, 0, "R7 sc without reservation");
      issue(1, 2'd1, 32'h0000_1003, 0, "R2 load-reserved");
      issue(1, 2'd0, 32'h0000_2000, 0, "R3 plain load");
      issue(1, 2'd2, 32'h0000_2004, 0, "R3 store other granule");
      issue(0, 2'd0, 32'h0,          0, "R3 idle");
      issue(1, 2'd3, 32'h0000_1001, 0, "R5 sc match");
      issue(0, 2'd0, 32'h0,          0, "R8 cleared after sc");

      issue(1, 2'd1, 32'h0000_0040, 0, "R2 load-reserved 2");
      issue(1, 2'd3, 32'h0000_0044, 0, "R6 sc other granule");
      issue(1, 2'd3, 32'h0000_0040, 0, "R8 second sc fails");

      issue(1, 2'd1, 32'h0000_0080, 0, "R2 load-reserved 3");
      issue(0, 2'd0, 32'h0,          1, "R4 ext clear alone");
      issue(1, 2'd3, 32'h0000_0080, 0, "R7 sc after clear");

      issue(1, 2'd1, 32'h0000_0090, 1, "R9 clear with load-reserved");
      issue(1, 2'd3, 32'h0000_0090, 0, "R9 sc after lost race");

      issue(1, 2'd1, 32'h0000_00A0, 0, "R2 load-reserved 4");
      issue(1, 2'd3, 32'h0000_00A0, 1, "R10 clear with sc");

      issue(1, 2'd1, 32'h0000_00B0, 0, "R2 load-reserved 5");
      issue(1, 2'd2, 32'h0000_00B2, 0, "R11 store hits granule");
      issue(1, 2'd3, 32'h0000_00B0, 0, "R11 sc after store");

      issue(1, 2'd1, 32'h0000_00C0, 0, "R2 load-reserved 6");
      issue(1, 2'd1, 32'h0000_00D1, 0, "R2 replacing load-reserved");
      issue(1, 2'd0, 32'h0000_00D0, 1, "R4 clear during load");
      issue(1, 2'd1, 32'h0000_00E0, 0, "R2 load-reserved 7");
      issue(1, 2'd3, 32'h0000_00E3, 0, "R5 sc match low bits");
      issue(1, 2'd0, 32'h0000_0010, 0, "R12 plain load response");

      repeat (4) issue(0, 2'd0, 32'h0, 0, "R12 idle tail");
      @(negedge clk);
      check(AW'(exp_q.size()), '0, "R12 queue drained");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule